// File: doc/BRIEF.md
# Electronic Shutter Setting Capture and Decode

This block takes the electronic-shutter setting of a sensor timing chain and turns it into a 2-bit shutter mode and a 9-bit load value for the downstream shutter sequencers. A source-select input chooses how the setting arrives.

In parallel mode, three setting pins carry a speed code and two mode pins carry the mode. A fixed lookup, which depends on the TV standard, decodes them. In serial mode, the same three pins act as a strobe, a shift clock and a data line. A 12-bit frame shifts in. It carries the load value directly, followed by two mode bits, and those mode bits replace the mode pins.

All setting pins pass through a synchronizer into the system clock. A new decoded setting reaches the outputs only on a rising edge of the field-sync input, so a shutter period in progress is never altered. The serial receiver is a three-state machine:
- RX_IDLE moves to RX_ARMED when the strobe is high.
- RX_ARMED moves to RX_COPY when the strobe returns low.
- RX_COPY moves to RX_IDLE after one cycle, in which the shifted frame is copied to the staging register.

Top module: `shut_set_dec`

## Requirements
- R1: While reset is asserted, and after it is released until the first field-sync edge, shut_mode is 2'b11 and shut_load is 9'h1FF.
- R2: shut_mode is {first mode bit, second mode bit}. 2'b00 is flickerless, 2'b01 is high-speed, 2'b10 is low-speed and 2'b11 is off. In parallel mode, shut_mode takes the value of mode_pin[1:0] at the applying edge.
- R3: The parallel speed index is n = 7 - set_pin, where set_pin[0], set_pin[1] and set_pin[2] are the three setting pins. In high-speed mode, n = 1..7 gives these loads:
  - NTSC (std_pal = 0): 176h, 137h, 118h, 108h, 100h, 0FCh, 0FAh.
  - PAL: 143h, 105h, 0E6h, 0D6h, 0CEh, 0CAh, 0C8h.
- R4: In high-speed mode with set_pin = 3'b111 (n = 0, full field without discharge), the load is 1FFh.
- R5: In parallel low-speed mode, the load is 1FEh - n, which selects 2(n+1) fields.
- R6: In parallel flickerless mode, the load is 196h for NTSC and 149h for PAL. In off mode, the load is 1FFh.
- R7: In serial mode, set_pin[2] is sampled at each rising edge of set_pin[1]. A frame is 12 bits, sent in this order: load bits 0 to 8, then the first mode bit, then the second mode bit, then a dummy bit.
- R8: When the strobe set_pin[0] falls after having been high, the last 12 bits shifted in become the serial setting. Its mode bits override mode_pin completely.
- R9: The outputs change only in the cycle after a rising edge of fld_sync. Pin changes without that edge leave the outputs unchanged.
- R10: par_sel = 1 selects the parallel decode and par_sel = 0 selects the staged serial frame. The choice is made at the applying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | 1: parallel setting, 0: serial setting |
| std_pal | input | 1 | 0: NTSC table, 1: PAL table |
| set_pin | input | 3 | Speed code in parallel mode. In serial mode: [0] strobe, [1] clock, [2] data |
| mode_pin | input | 2 | Parallel shutter mode {first, second} |
| fld_sync | input | 1 | Field-sync; its rising edge applies the pending setting |
| shut_mode | output | 2 | Applied shutter mode |
| shut_load | output | 9 | Applied load value |

## Verification
A wrong receiver state or a misaligned shift register produces a load value whose bits are rotated, or mode bits taken from the wrong frame position. This appears on shut_load and shut_mode in the cycle after the next field-sync edge. A decode slip, such as a reversed index or a swapped standard, produces a load that differs from the arithmetic expectation for a specific code. Sweeping every code under every mode and standard therefore exposes it at the first affected setting. An apply path that ignores the edge shows up as an output that moves while field-sync is idle.

// File: rtl/shut_pkg.sv
package shut_pkg;
    typedef enum logic [1:0] {
        MD_FLICKERLESS = 2'b00,
        MD_FAST        = 2'b01,
        MD_SLOW        = 2'b10,
        MD_OFF         = 2'b11
    } shut_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'b00,
        RX_ARMED = 2'b01,
        RX_COPY  = 2'b10
    } rx_state_e;
endpackage

// File: rtl/shut_sync.sv
module shut_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/shut_ser_rx.sv
module shut_ser_rx
    import shut_pkg::*;
#(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb_i,
    input  logic               sck_i,
    input  logic               sdat_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic               sck_d;
    logic [FRAME_W-1:0] shreg;
    rx_state_e          st_q, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            shreg <= '0;
        end else begin
            sck_d <= sck_i;
            if (sck_i && !sck_d) begin
                shreg <= {sdat_i, shreg[FRAME_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RX_IDLE;
        end else begin
            st_q <= st_n;
        end
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            RX_IDLE:  if (stb_i)  st_n = RX_ARMED;
            RX_ARMED: if (!stb_i) st_n = RX_COPY;
            RX_COPY:  st_n = RX_IDLE;
            default:  st_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_o <= '1;
        end else if (st_q == RX_COPY) begin
            frame_o <= shreg;
        end
    end
endmodule

// File: rtl/shut_par_dec.sv
module shut_par_dec
    import shut_pkg::*;
#(
    parameter int LOAD_W = 9
) (
    input  logic [2:0]        code_i,
    input  logic [1:0]        mode_i,
    input  logic              pal_i,
    output logic [1:0]        mode_o,
    output logic [LOAD_W-1:0] load_o
);
    localparam logic [LOAD_W-1:0] LOAD_FULL = LOAD_W'(9'h1FF);
    localparam logic [LOAD_W-1:0] LOAD_SLOW = LOAD_W'(9'h1FE);

    logic [2:0]        idx;
    logic [LOAD_W-1:0] fast_ntsc, fast_pal;

    assign idx    = ~code_i;
    assign mode_o = mode_i;

    always_comb begin
        unique case (idx)
            3'd1:    begin fast_ntsc = LOAD_W'(9'h176); fast_pal = LOAD_W'(9'h143); end
            3'd2:    begin fast_ntsc = LOAD_W'(9'h137); fast_pal = LOAD_W'(9'h105); end
            3'd3:    begin fast_ntsc = LOAD_W'(9'h118); fast_pal = LOAD_W'(9'h0E6); end
            3'd4:    begin fast_ntsc = LOAD_W'(9'h108); fast_pal = LOAD_W'(9'h0D6); end
            3'd5:    begin fast_ntsc = LOAD_W'(9'h100); fast_pal = LOAD_W'(9'h0CE); end
            3'd6:    begin fast_ntsc = LOAD_W'(9'h0FC); fast_pal = LOAD_W'(9'h0CA); end
            3'd7:    begin fast_ntsc = LOAD_W'(9'h0FA); fast_pal = LOAD_W'(9'h0C8); end
            default: begin fast_ntsc = LOAD_FULL;      fast_pal = LOAD_FULL;      end
        endcase
    end

    always_comb begin
        unique case (shut_mode_e'(mode_i))
            MD_FLICKERLESS: load_o = pal_i ? LOAD_W'(9'h149) : LOAD_W'(9'h196);
            MD_FAST:        load_o = pal_i ? fast_pal : fast_ntsc;
            MD_SLOW:        load_o = LOAD_SLOW - LOAD_W'(idx);
            default:        load_o = LOAD_FULL;
        endcase
    end
endmodule

// File: rtl/shut_set_dec.sv
module shut_set_dec
    import shut_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOAD_W      = 9,
    parameter int FRAME_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_sel,
    input  logic              std_pal,
    input  logic [2:0]        set_pin,
    input  logic [1:0]        mode_pin,
    input  logic              fld_sync,
    output logic [1:0]        shut_mode,
    output logic [LOAD_W-1:0] shut_load
);
    localparam int SYNC_W  = 7;
    localparam int M1_BIT  = LOAD_W;
    localparam int M2_BIT  = LOAD_W + 1;

    logic [SYNC_W-1:0]  raw_in, syn;
    logic [2:0]         s_pin;
    logic [1:0]         s_mode;
    logic               s_pal, s_par;
    logic [FRAME_W-1:0] ser_frame;
    logic [1:0]         dec_mode;
    logic [LOAD_W-1:0]  dec_load;
    logic               fs_d, apply;

    assign raw_in = {par_sel, std_pal, mode_pin, set_pin};
    assign {s_par, s_pal, s_mode, s_pin} = syn;

    shut_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn)
    );

    shut_ser_rx #(.FRAME_W(FRAME_W)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (s_pin[0]),
        .sck_i   (s_pin[1]),
        .sdat_i  (s_pin[2]),
        .frame_o (ser_frame)
    );

    shut_par_dec #(.LOAD_W(LOAD_W)) dec_i (
        .code_i (s_pin),
        .mode_i (s_mode),
        .pal_i  (s_pal),
        .mode_o (dec_mode),
        .load_o (dec_load)
    );

    assign apply = fld_sync && !fs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_d      <= 1'b0;
            shut_mode <= MD_OFF;
            shut_load <= '1;
        end else begin
            fs_d <= fld_sync;
            if (apply) begin
                if (s_par) begin
                    shut_mode <= dec_mode;
                    shut_load <= dec_load;
                end else begin
                    shut_mode <= {ser_frame[M1_BIT], ser_frame[M2_BIT]};
                    shut_load <= ser_frame[LOAD_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/shut_set_dec_chk.sv
module shut_set_dec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       par_sel,
    input logic       std_pal,
    input logic [2:0] set_pin,
    input logic [1:0] mode_pin,
    input logic       fld_sync,
    input logic [1:0] shut_mode,
    input logic [8:0] shut_load
);
    logic [6:0] cur, prev;
    logic [2:0] stab_cnt;
    logic       fs_prev;
    logic       edge_now, steady;

    assign cur      = {par_sel, std_pal, mode_pin, set_pin};
    assign edge_now = fld_sync && !fs_prev;
    assign steady   = par_sel && (cur == prev) && (stab_cnt >= 3'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev     <= '0;
            stab_cnt <= '0;
            fs_prev  <= 1'b0;
        end else begin
            prev     <= cur;
            fs_prev  <= fld_sync;
            if (cur != prev)             stab_cnt <= '0;
            else if (stab_cnt != 3'd7)   stab_cnt <= stab_cnt + 3'd1;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (shut_mode == 2'b11 && shut_load == 9'h1FF));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_now |=> $stable({shut_mode, shut_load}));

    p_mode_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && edge_now) |=> (shut_mode == $past(mode_pin)));

    p_slow_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && edge_now && mode_pin == 2'b10) |=>
        (shut_load >= 9'h1F7 && shut_load <= 9'h1FE));

    p_off_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && edge_now && mode_pin == 2'b11) |=> (shut_load == 9'h1FF));
endmodule

bind shut_set_dec shut_set_dec_chk chk_i (.*);

// File: tb/shut_set_dec_tb.sv
module shut_set_dec_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_sel = 1'b1;
    logic       std_pal = 1'b0;
    logic [2:0] set_pin = 3'b000;
    logic [1:0] mode_pin = 2'b11;
    logic       fld_sync = 1'b0;
    logic [1:0] shut_mode;
    logic [8:0] shut_load;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shut_set_dec dut_i (
        .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .std_pal(std_pal),
        .set_pin(set_pin), .mode_pin(mode_pin), .fld_sync(fld_sync),
        .shut_mode(shut_mode), .shut_load(shut_load)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_field();
        fld_sync = 1'b1;
        wait_cyc(3);
        fld_sync = 1'b0;
        wait_cyc(3);
    endtask

    function automatic int exp_load(input int pal, input int md, input int code);
        int n;
        n = 7 - code;
        case (md)
            0: return pal ? 'h149 : 'h196;
            1: begin
                if (n == 0) return 'h1FF;
                if (pal == 0) begin
                    case (n)
                        1: return 'h176; 2: return 'h137; 3: return 'h118;
                        4: return 'h108; 5: return 'h100; 6: return 'h0FC;
                        default: return 'h0FA;
                    endcase
                end else begin
                    case (n)
                        1: return 'h143; 2: return 'h105; 3: return 'h0E6;
                        4: return 'h0D6; 5: return 'h0CE; 6: return 'h0CA;
                        default: return 'h0C8;
                    endcase
                end
            end
            2: return 'h1FE - n;
            default: return 'h1FF;
        endcase
    endfunction

    task automatic send_frame(input logic [8:0] val, input logic [1:0] md);
        for (int i = 0; i < 12; i++) begin
            set_pin[2] = (i < 9) ? val[i] : (i == 9) ? md[1] : (i == 10) ? md[0] : 1'b0;
            wait_cyc(3);
            set_pin[1] = 1'b1;
            wait_cyc(3);
            set_pin[1] = 1'b0;
            wait_cyc(1);
        end
        set_pin[0] = 1'b1;
        wait_cyc(4);
        set_pin[0] = 1'b0;
        wait_cyc(8);
    endtask

    initial begin
        wait_cyc(3);
        check(shut_mode == 2'b11 && shut_load == 9'h1FF, "R1 in reset", {shut_mode, shut_load}, 'h7FF);
        rst_n = 1'b1;
        wait_cyc(5);
        check(shut_mode == 2'b11 && shut_load == 9'h1FF, "R1 after release", {shut_mode, shut_load}, 'h7FF);

        // R2 R3 R4 R5 R6 R10: full parallel sweep
        par_sel = 1'b1;
        for (int pal = 0; pal < 2; pal++) begin
            for (int md = 0; md < 4; md++) begin
                for (int code = 0; code < 8; code++) begin
                    std_pal = pal[0];
                    mode_pin = md[1:0];
                    set_pin = code[2:0];
                    wait_cyc(6);
                    pulse_field();
                    check(shut_mode == md[1:0], "R2 parallel mode", shut_mode, md);
                    check(int'(shut_load) == exp_load(pal, md, code),
                          (md == 1) ? ((code == 7) ? "R4 full field" : "R3 fast table") :
                          (md == 2) ? "R5 slow fields" : "R6 flickerless/off",
                          shut_load, exp_load(pal, md, code));
                end
            end
        end

        // R9: pin change without field edge leaves outputs alone
        mode_pin = 2'b10;
        set_pin = 3'b000;
        wait_cyc(20);
        check(shut_mode == 2'b11 && shut_load == 9'h1FF, "R9 no edge hold", {shut_mode, shut_load}, 'h7FF);
        pulse_field();
        check(shut_load == 9'h1F7, "R9 edge applies", shut_load, 'h1F7);

        // R7 R8 R10: serial frames, pins set opposite to frame mode
        par_sel = 1'b0;
        set_pin = 3'b000;
        wait_cyc(6);
        for (int i = 0; i < 8; i++) begin
            logic [8:0] v;
            logic [1:0] m;
            v = 9'((i * 37 + 5) % 512);
            m = 2'(i % 4);
            mode_pin = ~m;
            send_frame(v, m);
            pulse_field();
            check(shut_load == v, "R7 serial load", shut_load, v);
            check(shut_mode == m, "R8 serial mode override", shut_mode, m);
        end

        // R8: frame shifted but strobe not pulsed is not applied
        set_pin[2] = 1'b1;
        for (int i = 0; i < 12; i++) begin
            set_pin[1] = 1'b1; wait_cyc(3);
            set_pin[1] = 1'b0; wait_cyc(3);
        end
        pulse_field();
        check(shut_load == 9'((7 * 37 + 5) % 512), "R8 no strobe keeps frame", shut_load, (7 * 37 + 5) % 512);

        // R10: back to parallel
        par_sel = 1'b1;
        std_pal = 1'b1;
        mode_pin = 2'b00;
        wait_cyc(6);
        pulse_field();
        check(shut_load == 9'h149 && shut_mode == 2'b00, "R10 back to parallel", shut_load, 'h149);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule